// File: doc/BRIEF.md
# Oscillator Enable and CPU Clock Source Controller

This block sits in the clock generator of a small microcontroller and turns software register bits, a power-on option and the CPU operating mode into control for three clock sources: a high-speed system oscillator, an internal ring oscillator and an always-running subsystem clock. It drives an enable for each of the two stoppable oscillators, a code naming the source that clocks the CPU, and an enable and source code for the peripheral prescaler clock. Analog oscillators and glitch-free muxing sit outside. The block only decides what they should do.

Software writes one 8-bit field at a time through a strobe, a 2-bit address and a data byte. The register that stops the high-speed oscillator depends on which clock feeds the CPU. The block checks every write against the state it would produce. A write that would leave the CPU source without a running oscillator is dropped and raises a sticky error flag. STOP and HALT requests gate the CPU clock and keep the entry-time source for the peripherals. A wake event returns to normal running on the next edge.

Top module: `clkgen_osc_ctrl`

## Requirements
- R1: After synchronous active-low reset: high-speed enable 0, ring enable 1, CPU select 2'b00, peripheral enable 1, peripheral select 2'b00, error flag 0.
- R2: While the subsystem source is not chosen, the high-speed enable equals the inverse of address 0 bit 7, and address 1 bit 7 has no effect on it.
- R3: Address 1 bit 4 set chooses the subsystem clock. The high-speed enable then equals the inverse of address 1 bit 7, and address 0 bit 7 has no effect on it.
- R4: Address 2 bit 0 stops the ring oscillator only when the option input allows software stop. Otherwise the ring enable stays 1.
- R5: CPU select codes are 2'b10 for subsystem (address 1 bit 4 set), 2'b01 for high-speed (address 3 bit 0 set), and 2'b00 for ring in all other cases.
- R6: A write that would leave the selected CPU source's oscillator disabled is ignored and sets the error flag. This includes both oscillators stopped while the ring clocks the CPU, and selecting the high-speed clock while its enable is 0.
- R7: Writing address 3 with bit 7 set clears the error flag. If that same write is rejected, the flag stays set.
- R8: A STOP request in running mode gives CPU select 2'b11 and peripheral enable 0 from the next edge. The peripheral select holds the entry-time CPU source and the oscillator enables do not change. STOP wins when STOP and HALT arrive together.
- R9: A HALT request in running mode gives CPU select 2'b11 from the next edge. Peripheral enable stays 1 and the peripheral select holds the entry-time CPU source.
- R10: A wake event in STOP or HALT returns to running mode on the next edge and restores the CPU select in effect before entry.
- R11: Register writes in STOP or HALT are ignored and raise no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Write data |
| opt_ring_soft_stop | input | 1 | Power-on option: software may stop the ring oscillator |
| stop_req | input | 1 | Enter STOP mode |
| halt_req | input | 1 | Enter HALT mode |
| wake | input | 1 | Wake event leaving STOP or HALT |
| hs_osc_en | output | 1 | High-speed oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| cpu_clk_sel | output | 2 | CPU clock source code (11 = gated) |
| periph_clk_en | output | 1 | Peripheral prescaler clock enable |
| periph_clk_sel | output | 2 | Peripheral clock source code |
| cfg_err | output | 1 | Sticky prohibited-setting flag |

## Verification
The flag logic has two paths that can act in the same cycle: the clear path and the rejection path. One write to address 3 can carry a rejected source choice together with the clear bit. The bench drives exactly that write with the high-speed oscillator stopped and expects the flag to stay 1. In the same way, a single cycle carrying both STOP and HALT must land in STOP, which the bench judges by a 0 peripheral enable.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MAIN  = 2'd0;
  localparam logic [ADDR_W-1:0] A_PROC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_RING  = 2'd2;
  localparam logic [ADDR_W-1:0] A_MODE  = 2'd3;

  localparam int B_HS_OFF  = 7;
  localparam int B_USE_SUB = 4;
  localparam int B_RING_OFF = 0;
  localparam int B_SEL_HS  = 0;
  localparam int B_ERR_CLR = 7;

  typedef enum logic [1:0] {
    SRC_RING = 2'b00,
    SRC_HS   = 2'b01,
    SRC_SUB  = 2'b10,
    SRC_NONE = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    M_RUN  = 2'd0,
    M_STOP = 2'd1,
    M_HALT = 2'd2
  } mode_e;

  typedef struct packed {
    logic main_hs_off;
    logic proc_hs_off;
    logic use_sub;
    logic ring_off;
    logic sel_hs;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{main_hs_off: 1'b1, proc_hs_off: 1'b1,
                                 use_sub: 1'b0, ring_off: 1'b0, sel_hs: 1'b0};

  function automatic logic hs_enable(input cfg_t c);
    return c.use_sub ? !c.proc_hs_off : !c.main_hs_off;
  endfunction

  function automatic logic ring_enable(input logic soft_ok, input cfg_t c);
    return !(soft_ok && c.ring_off);
  endfunction

  function automatic src_e cpu_source(input cfg_t c);
    if (c.use_sub) return SRC_SUB;
    if (c.sel_hs)  return SRC_HS;
    return SRC_RING;
  endfunction

  function automatic logic src_alive(input src_e s, input logic hs_on, input logic ring_on);
    case (s)
      SRC_RING: return ring_on;
      SRC_HS:   return hs_on;
      SRC_SUB:  return 1'b1;
      default:  return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_cfg_regs.sv
module clkgen_cfg_regs
  import clkgen_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          soft_ok,
  input  logic          wr_allow,
  output logic          hs_on,
  output logic          ring_on,
  output src_e          live_src,
  output logic          err
);

  cfg_t cfg_q, cand;
  logic wr_fire, cand_ok, wr_reject, wr_accept, err_clr;
  logic [DW-1:0] wr_data_unused;

  assign wr_data_unused = wr_data;
  assign wr_fire = wr_en && wr_allow;

  always_comb begin
    cand = cfg_q;
    if (wr_fire) begin
      case (wr_addr)
        A_MAIN: cand.main_hs_off = wr_data[B_HS_OFF];
        A_PROC: begin
          cand.proc_hs_off = wr_data[B_HS_OFF];
          cand.use_sub     = wr_data[B_USE_SUB];
        end
        A_RING: cand.ring_off = wr_data[B_RING_OFF];
        default: cand.sel_hs = wr_data[B_SEL_HS];
      endcase
    end
  end

  assign cand_ok   = src_alive(cpu_source(cand), hs_enable(cand), ring_enable(soft_ok, cand));
  assign wr_reject = wr_fire && !cand_ok;
  assign wr_accept = wr_fire && cand_ok;
  assign err_clr   = wr_fire && (wr_addr == A_MODE) && wr_data[B_ERR_CLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
      err   <= 1'b0;
    end else begin
      if (wr_accept) cfg_q <= cand;
      if (wr_reject)    err <= 1'b1;
      else if (err_clr) err <= 1'b0;
    end
  end

  assign hs_on    = hs_enable(cfg_q);
  assign ring_on  = ring_enable(soft_ok, cfg_q);
  assign live_src = cpu_source(cfg_q);

  assert_src_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_alive(live_src, hs_on, ring_on));

  assert_reject_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> $stable(cfg_q));

  assert_reject_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> err);

  assert_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_allow) |=> ($stable(cfg_q) && $stable(err)));

endmodule

// File: rtl/clkgen_mode_ctl.sv
module clkgen_mode_ctl
  import clkgen_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic halt_req,
  input  logic wake,
  input  src_e live_src,
  output logic wr_allow,
  output src_e cpu_sel,
  output logic periph_en,
  output src_e periph_sel
);

  mode_e mode_q;
  src_e  saved_q;
  logic  enter_stop, enter_halt, leave_lp;

  assign enter_stop = (mode_q == M_RUN) && stop_req;
  assign enter_halt = (mode_q == M_RUN) && !stop_req && halt_req;
  assign leave_lp   = (mode_q != M_RUN) && wake;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= M_RUN;
      saved_q <= SRC_RING;
    end else begin
      if (enter_stop) begin
        mode_q  <= M_STOP;
        saved_q <= live_src;
      end else if (enter_halt) begin
        mode_q  <= M_HALT;
        saved_q <= live_src;
      end else if (leave_lp) begin
        mode_q  <= M_RUN;
      end
    end
  end

  assign wr_allow   = (mode_q == M_RUN);
  assign cpu_sel    = wr_allow ? live_src : SRC_NONE;
  assign periph_en  = (mode_q != M_STOP);
  assign periph_sel = wr_allow ? live_src : saved_q;

  assert_enter_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    enter_stop |=> (cpu_sel == SRC_NONE && !periph_en && periph_sel == $past(live_src)));

  assert_enter_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    enter_halt |=> (cpu_sel == SRC_NONE && periph_en && periph_sel == $past(live_src)));

  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    leave_lp |=> (cpu_sel == saved_q && wr_allow));

endmodule

// File: rtl/clkgen_osc_ctrl.sv
module clkgen_osc_ctrl
  import clkgen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              opt_ring_soft_stop,
  input  logic              stop_req,
  input  logic              halt_req,
  input  logic              wake,
  output logic              hs_osc_en,
  output logic              ring_osc_en,
  output logic [1:0]        cpu_clk_sel,
  output logic              periph_clk_en,
  output logic [1:0]        periph_clk_sel,
  output logic              cfg_err
);

  logic wr_allow;
  src_e live_src, cpu_sel_e, periph_sel_e;

  clkgen_cfg_regs #(.DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .soft_ok  (opt_ring_soft_stop),
    .wr_allow (wr_allow),
    .hs_on    (hs_osc_en),
    .ring_on  (ring_osc_en),
    .live_src (live_src),
    .err      (cfg_err)
  );

  clkgen_mode_ctl u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_req   (stop_req),
    .halt_req   (halt_req),
    .wake       (wake),
    .live_src   (live_src),
    .wr_allow   (wr_allow),
    .cpu_sel    (cpu_sel_e),
    .periph_en  (periph_clk_en),
    .periph_sel (periph_sel_e)
  );

  assign cpu_clk_sel    = cpu_sel_e;
  assign periph_clk_sel = periph_sel_e;

  assert_ring_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !opt_ring_soft_stop |-> ring_osc_en);

  assert_stop_osc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!periph_clk_en && $past(!periph_clk_en)) |-> ($stable(hs_osc_en) && $stable(ring_osc_en)));

endmodule

// File: tb/sim_clkgen_osc_ctrl.sv
module sim_clkgen_osc_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       opt = 1'b0;
  logic       stop_req = 1'b0, halt_req = 1'b0, wake = 1'b0;
  logic       hs_en, ring_en, p_en, err;
  logic [1:0] cpu_sel, p_sel;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  clkgen_osc_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .opt_ring_soft_stop(opt), .stop_req(stop_req), .halt_req(halt_req), .wake(wake),
    .hs_osc_en(hs_en), .ring_osc_en(ring_en), .cpu_clk_sel(cpu_sel),
    .periph_clk_en(p_en), .periph_clk_sel(p_sel), .cfg_err(err)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic o);
    @(negedge clk);
    rst_n = 1'b0; opt = o;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic s, input logic h, input logic w);
    @(negedge clk);
    stop_req = s; halt_req = h; wake = w;
    @(negedge clk);
    stop_req = 1'b0; halt_req = 1'b0; wake = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    check("R1 hs_en", hs_en, 0);
    check("R1 ring_en", ring_en, 1);
    check("R1 cpu_sel", cpu_sel, 2'b00);
    check("R1 p_en", p_en, 1);
    check("R1 p_sel", p_sel, 2'b00);
    check("R1 err", err, 0);
  endtask

  task automatic t_main_bit;
    do_reset(1'b0);
    wr(2'd0, 8'h00); check("R2 start hs", hs_en, 1);
    wr(2'd1, 8'h80); check("R2 proc bit ignored", hs_en, 1);
    wr(2'd1, 8'h00); check("R2 proc bit ignored 2", hs_en, 1);
    wr(2'd0, 8'h80); check("R2 stop hs", hs_en, 0);
    wr(2'd1, 8'h00); check("R2 proc bit ignored 3", hs_en, 0);
  endtask

  task automatic t_sub;
    do_reset(1'b0);
    wr(2'd1, 8'h10);
    check("R5 sub sel", cpu_sel, 2'b10);
    check("R3 hs via proc", hs_en, 1);
    wr(2'd0, 8'h80); check("R3 main ignored", hs_en, 1);
    wr(2'd1, 8'h90); check("R3 proc stops hs", hs_en, 0);
    wr(2'd0, 8'h00); check("R3 main ignored 2", hs_en, 0);
    check("R3 no err", err, 0);
    wr(2'd1, 8'h00);
    check("R5 back to ring", cpu_sel, 2'b00);
    check("R2 main rules again", hs_en, 1);
  endtask

  task automatic t_sel_hs;
    do_reset(1'b0);
    wr(2'd3, 8'h01);
    check("R6 sel hs while off", cpu_sel, 2'b00);
    check("R6 err set", err, 1);
    wr(2'd3, 8'h81);
    check("R7 set wins", err, 1);
    wr(2'd3, 8'h80);
    check("R7 cleared", err, 0);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    check("R5 hs sel", cpu_sel, 2'b01);
    check("R6 accepted", err, 0);
    wr(2'd0, 8'h80);
    check("R6 hs stop blocked", hs_en, 1);
    check("R6 err on hs stop", err, 1);
    wr(2'd3, 8'h81);
    check("R7 clear keeps sel", err, 0);
    check("R5 still hs", cpu_sel, 2'b01);
  endtask

  task automatic t_ring;
    do_reset(1'b0);
    wr(2'd2, 8'h01);
    check("R4 option blocks stop", ring_en, 1);
    check("R4 no err", err, 0);
    do_reset(1'b1);
    wr(2'd2, 8'h01);
    check("R6 both stopped blocked", ring_en, 1);
    check("R6 err both", err, 1);
    wr(2'd3, 8'h80);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd2, 8'h01);
    check("R4 ring stops", ring_en, 0);
    check("R4 no err", err, 0);
    wr(2'd3, 8'h00);
    check("R6 back to dead ring", cpu_sel, 2'b01);
    check("R6 err dead ring", err, 1);
  endtask

  task automatic t_stop;
    do_reset(1'b0);
    wr(2'd0, 8'h00);
    pulse(1'b1, 1'b1, 1'b0);
    check("R8 cpu gated", cpu_sel, 2'b11);
    check("R8 periph off", p_en, 0);
    check("R8 periph sel", p_sel, 2'b00);
    check("R8 hs kept", hs_en, 1);
    check("R8 ring kept", ring_en, 1);
    wr(2'd3, 8'h01);
    check("R11 no err", err, 0);
    check("R11 still gated", cpu_sel, 2'b11);
    pulse(1'b0, 1'b0, 1'b1);
    check("R10 cpu restored", cpu_sel, 2'b00);
    check("R10 periph on", p_en, 1);
    check("R11 write dropped", cpu_sel, 2'b00);
  endtask

  task automatic t_halt;
    do_reset(1'b0);
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h01);
    pulse(1'b0, 1'b1, 1'b0);
    check("R9 cpu gated", cpu_sel, 2'b11);
    check("R9 periph on", p_en, 1);
    check("R9 periph sel", p_sel, 2'b01);
    pulse(1'b0, 1'b0, 1'b1);
    check("R10 hs restored", cpu_sel, 2'b01);
    pulse(1'b0, 1'b0, 1'b1);
    check("R10 wake in run", cpu_sel, 2'b01);
  endtask

  initial begin
    t_reset();
    t_main_bit();
    t_sub();
    t_sel_hs();
    t_ring();
    t_stop();
    t_halt();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule